// File: doc/BRIEF.md
# Phase-Inverting Serial Segment Driver

This block drives the segments of a capacitive display. Such a display is damaged by a steady DC level across a segment, so every output carries an alternating waveform. Display bits arrive one at a time on a serial data input. Each rising edge of a shift-clock input advances them one position along a chain. A rising edge on a load-strobe input then copies the whole chain into a holding register in a single step. The segment outputs take their pattern from that holding register.

A shared backplane output carries the polarity square wave unchanged. A segment whose held bit is 1 is lit: its output is the inverse of the polarity wave, half a period out of phase with the backplane. A segment whose held bit is 0 is dark: its output matches the backplane. A backlight output works the same way and is controlled by its own enable input. The chain is made of two 32-bit stages connected end to end, giving 64 segments. The last chain bit is brought out as a serial output so that further drivers can be cascaded.

The shift clock and the load strobe are sampled by the system clock. The block acts on their rising edges, so one pulse of any length counts as exactly one event.

Top module: `segment_driver`

## Requirements
- R1: While reset is asserted, the shift chain and the holding register are cleared. Every segment output therefore equals `polarity` (dark), and `serOut` is 0.
- R2: Each rising edge of `shiftClk` moves the chain by exactly one position. Holding `shiftClk` high for several cycles still moves it only once.
- R3: A new bit enters chain position 0, and every other bit moves up one position. `serOut` shows position 63, so it presents the bit that was shifted in 64 shift edges earlier, after passing through both 32-bit stages.
- R4: Shift edges never change the segment pattern. A segment output changes only when `polarity` changes or on a load edge.
- R5: A rising edge of `loadStb` copies all 64 chain bits into the holding register at the same time. Holding `loadStb` high afterwards does not copy again.
- R6: `backplane` equals `polarity` at all times.
- R7: For every index i, `segOut[i]` is the inverse of `polarity` when held bit i is 1 (lit), and equals `polarity` when held bit i is 0 (dark).
- R8: `backlightOut` equals `polarity` when `backlightOn` is 0, and equals its inverse when `backlightOn` is 1.
- R9: When a shift edge and a load edge fall in the same cycle, the holding register receives the chain contents from before that shift, and the chain still advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all control inputs |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial display data into chain position 0 |
| shiftClk | input | 1 | Shift clock; acts on its rising edge |
| loadStb | input | 1 | Load strobe; acts on its rising edge |
| polarity | input | 1 | Polarity square wave |
| backlightOn | input | 1 | Backlight enable |
| segOut | output | 64 | Segment drive outputs |
| backplane | output | 1 | Common backplane drive |
| backlightOut | output | 1 | Backlight drive |
| serOut | output | 1 | Last chain bit, for cascading further drivers |

## Verification
The hardest case to reach from the ports is the one where a shift edge and a load edge land in the same system-clock cycle. The holding register must then capture the chain as it was before that shift, while the chain still advances. The bench raises both inputs at the same falling clock edge after filling the chain with a known pattern. It then checks the segment pattern against the pre-shift chain, and checks `serOut` against the post-shift chain. Long pulses on each control input are used to confirm that a held level counts as only one event.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic load;
  } segStrobe_t;
endpackage

// File: rtl/segdrv_ctrl.sv
module segdrv_ctrl
  import segdrv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       shiftClk,
  input  logic       loadStb,
  output segStrobe_t strobe
);
  logic shiftPrev;
  logic loadPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftPrev <= 1'b0;
      loadPrev  <= 1'b0;
    end else begin
      shiftPrev <= shiftClk;
      loadPrev  <= loadStb;
    end
  end

  // Rising-edge detection: one strobe per pulse regardless of pulse length
  always_comb begin
    strobe.shift = shiftClk & ~shiftPrev;
    strobe.load  = loadStb & ~loadPrev;
  end
endmodule

// File: rtl/segdrv_stage.sv
module segdrv_stage
  import segdrv_pkg::*;
#(
  parameter int STAGE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  segStrobe_t         strobe,
  input  logic               serIn,
  input  logic               polarity,
  output logic               serOut,
  output logic [STAGE_W-1:0] segOut
);
  logic [STAGE_W-1:0] chain;
  logic [STAGE_W-1:0] hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      hold  <= '0;
    end else begin
      if (strobe.shift) chain <= {chain[STAGE_W-2:0], serIn};
      // Captures the pre-shift chain when both strobes coincide
      if (strobe.load)  hold  <= chain;
    end
  end

  assign serOut = chain[STAGE_W-1];
  assign segOut = hold ^ {STAGE_W{polarity}};
endmodule

// File: rtl/segdrv_datapath.sv
module segdrv_datapath
  import segdrv_pkg::*;
#(
  parameter int STAGE_W = 32,
  parameter int STAGES  = 2,
  localparam int SEG_W  = STAGE_W * STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  segStrobe_t       strobe,
  input  logic             serIn,
  input  logic             polarity,
  input  logic             backlightOn,
  output logic [SEG_W-1:0] segOut,
  output logic             backplane,
  output logic             backlightOut,
  output logic             serOut
);
  logic [STAGES:0] link;

  assign link[0] = serIn;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    segdrv_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .serIn   (link[k]),
      .polarity(polarity),
      .serOut  (link[k+1]),
      .segOut  (segOut[k*STAGE_W +: STAGE_W])
    );
  end

  assign serOut       = link[STAGES];
  assign backplane    = polarity;
  assign backlightOut = polarity ^ backlightOn;
endmodule

// File: rtl/segment_driver.sv
module segment_driver
  import segdrv_pkg::*;
#(
  parameter int STAGE_W = 32,
  parameter int STAGES  = 2,
  localparam int SEG_W  = STAGE_W * STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             loadStb,
  input  logic             polarity,
  input  logic             backlightOn,
  output logic [SEG_W-1:0] segOut,
  output logic             backplane,
  output logic             backlightOut,
  output logic             serOut
);
  segStrobe_t strobe;

  segdrv_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .shiftClk(shiftClk),
    .loadStb (loadStb),
    .strobe  (strobe)
  );

  segdrv_datapath #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .serIn       (serIn),
    .polarity    (polarity),
    .backlightOn (backlightOn),
    .segOut      (segOut),
    .backplane   (backplane),
    .backlightOut(backlightOut),
    .serOut      (serOut)
  );
endmodule

// File: rtl/segdrv_chk.sv
module segdrv_chk #(
  parameter int SEG_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             shiftClk,
  input logic             loadStb,
  input logic             polarity,
  input logic [SEG_W-1:0] segOut,
  input logic             backplane,
  input logic             serOut
);
  logic shiftSeen;
  logic loadSeen;
  logic [SEG_W-1:0] pattern;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftSeen <= 1'b0;
      loadSeen  <= 1'b0;
    end else begin
      shiftSeen <= shiftClk;
      loadSeen  <= loadStb;
    end
  end

  assign pattern = segOut ^ {SEG_W{backplane}};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (pattern == '0 && serOut == 1'b0));

  // R2
  shift_edge_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftClk && !shiftSeen) |=> $stable(serOut));

  // R4
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loadStb && !loadSeen) |=> $stable(pattern));

  // R6
  backplane_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    backplane == polarity);
endmodule

bind segment_driver segdrv_chk #(.SEG_W(SEG_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .shiftClk (shiftClk),
  .loadStb  (loadStb),
  .polarity (polarity),
  .segOut   (segOut),
  .backplane(backplane),
  .serOut   (serOut)
);

// File: tb/tb_segment_driver.sv
module tb_segment_driver;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic shiftClk = 1'b0;
  logic loadStb = 1'b0;
  logic polarity = 1'b0;
  logic backlightOn = 1'b0;
  logic [SEG_W-1:0] segOut;
  logic backplane;
  logic backlightOut;
  logic serOut;

  int checks = 0;
  int errors = 0;
  logic [SEG_W-1:0] expChain = '0;
  logic [SEG_W-1:0] expHold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segment_driver dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftClk(shiftClk),
    .loadStb(loadStb), .polarity(polarity), .backlightOn(backlightOn),
    .segOut(segOut), .backplane(backplane), .backlightOut(backlightOut),
    .serOut(serOut)
  );

  task automatic chk(input string req, input logic [SEG_W-1:0] act,
                     input logic [SEG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [SEG_W-1:0] makePat(input int s);
    logic [SEG_W-1:0] p;
    for (int i = 0; i < SEG_W; i++) p[i] = ((i * s + s * s) % 7) < 3;
    return p;
  endfunction

  // Expected segment outputs per R7
  function automatic logic [SEG_W-1:0] segExp(input logic [SEG_W-1:0] h,
                                               input logic pol);
    return h ^ {SEG_W{pol}};
  endfunction

  task automatic shiftBit(input logic b);
    @(negedge clk); serIn = b; shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0;
    expChain = {expChain[SEG_W-2:0], b};
  endtask

  task automatic loadPulse();
    @(negedge clk); loadStb = 1'b1;
    @(negedge clk); loadStb = 1'b0;
    expHold = expChain;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [SEG_W-1:0] p;
    logic [SEG_W-1:0] ser;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 dark in reset", segOut, segExp('0, 1'b0));
    polarity = 1'b1; #1;
    chk("R1 dark in reset pol1", segOut, segExp('0, 1'b1));
    chk("R1 serOut reset", {63'd0, serOut}, '0);
    @(negedge clk); rstN = 1'b1;
    polarity = 1'b0;

    // Pattern sweep: R3, R4, R5, R6, R7
    for (int s = 1; s <= 6; s++) begin
      p = makePat(s);
      for (int i = SEG_W - 1; i >= 0; i--) begin
        shiftBit(p[i]);
        // R3: serOut shows chain position 63
        chk("R3 serOut", {63'd0, serOut}, {63'd0, expChain[SEG_W-1]});
        if (i % 16 == 0)
          chk("R4 no change while shifting", segOut, segExp(expHold, polarity));
      end
      loadPulse();
      chk("R5 load copies chain", expHold, p);
      for (int pol = 0; pol < 2; pol++) begin
        polarity = pol[0]; #1;
        chk("R7 lit inverted dark in phase", segOut, segExp(p, polarity));
        chk("R6 backplane", {63'd0, backplane}, {63'd0, polarity});
      end
      polarity = ~polarity;
    end

    // R3: 64-edge delay through both stages
    ser = '0;
    p = makePat(9);
    for (int i = 0; i < SEG_W; i++) shiftBit(p[i]);
    for (int i = 0; i < SEG_W; i++) begin
      ser[i] = serOut;
      shiftBit(1'b0);
    end
    chk("R3 64-edge delay", ser, p);

    // R2: long shift pulse counts once
    for (int i = 0; i < SEG_W; i++) shiftBit(1'b0);
    @(negedge clk); serIn = 1'b1; shiftClk = 1'b1;
    repeat (5) @(negedge clk);
    shiftClk = 1'b0; serIn = 1'b0;
    expChain = {expChain[SEG_W-2:0], 1'b1};
    loadPulse();
    chk("R2 single shift for long pulse", segOut, segExp(64'd1, polarity));

    // R5: long load pulse copies once
    @(negedge clk); loadStb = 1'b1;
    expHold = expChain;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); serIn = 1'b1; shiftClk = 1'b1;
      @(negedge clk); shiftClk = 1'b0;
    end
    chk("R5 held load no recopy", segOut, segExp(expHold, polarity));
    @(negedge clk); loadStb = 1'b0;
    expChain = {expChain[SEG_W-5:0], 4'b1111};

    // R9: coincident shift and load
    p = makePat(4);
    for (int i = SEG_W - 1; i >= 0; i--) shiftBit(p[i]);
    @(negedge clk); serIn = 1'b1; shiftClk = 1'b1; loadStb = 1'b1;
    @(negedge clk); shiftClk = 1'b0; loadStb = 1'b0;
    expHold = expChain;
    expChain = {expChain[SEG_W-2:0], 1'b1};
    chk("R9 hold gets pre-shift chain", segOut, segExp(p, polarity));
    chk("R9 chain still advanced", {63'd0, serOut}, {63'd0, expChain[SEG_W-1]});
    loadPulse();
    chk("R9 post-shift chain loaded", segOut, segExp(expChain, polarity));

    // R8: backlight drive
    for (int k = 0; k < 4; k++) begin
      backlightOn = k[1]; polarity = k[0]; #1;
      chk("R8 backlight", {63'd0, backlightOut}, {63'd0, k[0] ^ k[1]});
    end

    // R1: reset again from a loaded state
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset clears hold", segOut, segExp('0, polarity));
    chk("R1 reset clears chain", {63'd0, serOut}, '0);
    finishRun();
  end
endmodule